// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block keeps a DRAM array refreshed on its own. A free-running prescaler divides the system clock by one of seven ratios. An interval counter advances on each prescaled tick and fires when it reaches a programmed compare value. Each firing adds a chosen number of refresh credits to a saturating pending count. While credits remain, the controller asks the bus arbiter for the bus. Once the bus is granted, it runs one CAS-before-RAS cycle per credit, back to back, and keeps the bus until every credit is used.

A separate self-refresh request takes the bus in the same way. It performs the CAS-before-RAS entry and then holds both strobes low for as long as the request stays high. When the request drops, both strobes go high and a fixed recovery delay runs before the controller reports idle again. Interval counting continues during self-refresh, so credits gathered meanwhile are issued after the exit.

States: IDLE (bus released), ARB (bus requested, waiting for grant), CAS_LEAD, RAS_LO1, RAS_LO2, PRE1, PRE2 (one auto-refresh cycle), SR_LEAD, SR_HOLD, SR_EXIT (self-refresh). Transitions: IDLE→ARB on a self request or a nonzero pending count. ARB→SR_LEAD on grant with the self request high. ARB→CAS_LEAD on grant otherwise. ARB→IDLE when nothing is wanted any more. CAS_LEAD→RAS_LO1→RAS_LO2→PRE1→PRE2 in fixed order. PRE2 picks SR_LEAD or CAS_LEAD on grant, ARB without grant, and IDLE when nothing is wanted. SR_LEAD→SR_HOLD. SR_HOLD→SR_EXIT when the self request drops. SR_EXIT→IDLE after the recovery count.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, ras_n and cas_n are 1, bus_req is 0 and idle is 1.
- R2: div_sel codes 1 to 7 make one prescaled tick every 4, 16, 64, 256, 1024, 2048 or 4096 clocks. Code 0 halts interval counting, so no refresh is ever requested.
- R3: The interval counter clears and fires when an increment would reach or pass ivl_cmp. With a constant setting, requests repeat every ivl_cmp × divide-ratio clocks.
- R4: Each firing adds refresh credits set by burst_sel: code 0 adds 1, 1 adds 2, 2 adds 4, 3 adds 6, and codes 4 to 7 add 8. Exactly that many CBR cycles follow.
- R5: The pending count saturates at 15 and never wraps.
- R6: bus_req rises when credits or a self request are present in IDLE. No strobe goes low before bus_gnt is seen high.
- R7: A CBR cycle is CAS low with RAS high for 1 clock, then both low for 2 clocks, then both high for 2 clocks. RAS never falls while CAS is high.
- R8: bus_req stays high without a gap across back-to-back CBR cycles. It is released only when no credits remain.
- R9: A self request has priority over pending credits. It gives 1 clock of CAS-only low, then both strobes low for as long as self_req stays high.
- R10: After self_req drops, both strobes are high for SR_EXIT_CYC clocks (default 4) with idle low. Then idle returns and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 3 | Prescaler ratio code, 0 halts counting |
| ivl_cmp | input | CMP_W (8) | Interval compare value in prescaled ticks |
| burst_sel | input | 3 | Credits added per interval |
| self_req | input | 1 | Enter and hold self-refresh while high |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| idle | output | 1 | Controller idle and bus released |

## Verification
The hardest case to reach is the saturated pending count. It can only build up while the arbiter holds the grant back for many intervals. The bench therefore gates the grant off, runs the shortest interval with the largest burst for several periods, halts the prescaler, and then expects exactly fifteen cycles. Exact burst sizes are isolated the same way: the bench stops the prescaler as soon as the request rises, so a single firing's credits are counted. Self-refresh priority is set up by parking the controller in ARB with one credit pending and then raising the self request before the grant.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARB,
        ST_CAS_LEAD,
        ST_RAS_LO1,
        ST_RAS_LO2,
        ST_PRE1,
        ST_PRE2,
        ST_SR_LEAD,
        ST_SR_HOLD,
        ST_SR_EXIT
    } rfr_state_e;

    localparam int PS_W = 12;

    // low-bit mask whose all-ones pattern marks one prescaled tick
    function automatic logic [PS_W-1:0] tick_mask(input logic [2:0] code);
        logic [PS_W-1:0] m;
        unique case (code)
            3'd1:    m = 12'h003;
            3'd2:    m = 12'h00F;
            3'd3:    m = 12'h03F;
            3'd4:    m = 12'h0FF;
            3'd5:    m = 12'h3FF;
            3'd6:    m = 12'h7FF;
            3'd7:    m = 12'hFFF;
            default: m = 12'h000;
        endcase
        return m;
    endfunction

    function automatic logic [3:0] burst_credits(input logic [2:0] code);
        logic [3:0] n;
        unique case (code)
            3'd0:    n = 4'd1;
            3'd1:    n = 4'd2;
            3'd2:    n = 4'd4;
            3'd3:    n = 4'd6;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rfr_prescale.sv
module rfr_prescale
    import rfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_sel,
    output logic       tick
);
    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n) ps_cnt <= '0;
        else        ps_cnt <= ps_cnt + 1'b1;
    end

    always_comb begin
        mask = tick_mask(div_sel);
        tick = (div_sel != 3'd0) && ((ps_cnt & mask) == mask);
    end

    // ticks are never adjacent: the smallest ratio is four
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rfr_interval.sv
module rfr_interval #(
    parameter int CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CMP_W-1:0] ivl_cmp,
    output logic             match
);
    logic [CMP_W-1:0] ivl_cnt;
    logic [CMP_W:0]   ivl_inc;

    assign ivl_inc = {1'b0, ivl_cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_cnt <= '0;
            match   <= 1'b0;
        end else begin
            match <= 1'b0;
            if (tick) begin
                if (ivl_inc >= {1'b0, ivl_cmp}) begin
                    ivl_cnt <= '0;
                    match   <= 1'b1;
                end else begin
                    ivl_cnt <= ivl_inc[CMP_W-1:0];
                end
            end
        end
    end

    assert_match_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (ivl_cnt == '0) && $past(tick));
endmodule

// File: rtl/rfr_pending.sv
module rfr_pending #(
    parameter int MAX_PEND = 15,
    parameter int PW       = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [3:0]    add_amt,
    input  logic          take,
    output logic [PW-1:0] pend
);
    localparam int SW = PW + 5;

    logic [SW-1:0] sum;
    logic          take_ok;

    always_comb begin
        take_ok = take && (pend != '0);
        sum     = SW'(pend) + (add_en ? SW'(add_amt) : '0) - SW'(take_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 pend <= '0;
        else if (sum > SW'(MAX_PEND)) pend <= PW'(MAX_PEND);
        else                        pend <= sum[PW-1:0];
    end

    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) == PW'(MAX_PEND) && !$past(take)) |-> pend == PW'(MAX_PEND));
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take) |-> pend >= $past(pend));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import rfr_pkg::*;
#(
    parameter int CMP_W       = 8,
    parameter int MAX_PEND    = 15,
    parameter int SR_EXIT_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       div_sel,
    input  logic [CMP_W-1:0] ivl_cmp,
    input  logic [2:0]       burst_sel,
    input  logic             self_req,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             ras_n,
    output logic             cas_n,
    output logic             idle
);
    localparam int PW  = $clog2(MAX_PEND + 1);
    localparam int EXW = $clog2(SR_EXIT_CYC + 1);

    logic          tick;
    logic          match;
    logic [PW-1:0] pend;
    logic          want;
    logic [EXW-1:0] exit_cnt;

    rfr_state_e state, state_nxt;

    rfr_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick)
    );

    rfr_interval #(.CMP_W(CMP_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ivl_cmp (ivl_cmp),
        .match   (match)
    );

    rfr_pending #(.MAX_PEND(MAX_PEND), .PW(PW)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (match),
        .add_amt (burst_credits(burst_sel)),
        .take    (state == ST_CAS_LEAD),
        .pend    (pend)
    );

    assign want = (pend != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            exit_cnt <= '0;
        end else begin
            state    <= state_nxt;
            exit_cnt <= (state == ST_SR_EXIT) ? exit_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (self_req || want) state_nxt = ST_ARB;
            ST_ARB: begin
                if (!(self_req || want)) state_nxt = ST_IDLE;
                else if (bus_gnt)        state_nxt = self_req ? ST_SR_LEAD : ST_CAS_LEAD;
            end
            ST_CAS_LEAD: state_nxt = ST_RAS_LO1;
            ST_RAS_LO1:  state_nxt = ST_RAS_LO2;
            ST_RAS_LO2:  state_nxt = ST_PRE1;
            ST_PRE1:     state_nxt = ST_PRE2;
            ST_PRE2: begin
                if (!(self_req || want)) state_nxt = ST_IDLE;
                else if (bus_gnt)        state_nxt = self_req ? ST_SR_LEAD : ST_CAS_LEAD;
                else                     state_nxt = ST_ARB;
            end
            ST_SR_LEAD:  state_nxt = ST_SR_HOLD;
            ST_SR_HOLD:  if (!self_req) state_nxt = ST_SR_EXIT;
            ST_SR_EXIT:  if (exit_cnt == EXW'(SR_EXIT_CYC - 1)) state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req = (state != ST_IDLE);
        idle    = (state == ST_IDLE);
        cas_n   = 1'b1;
        ras_n   = 1'b1;
        unique case (state)
            ST_CAS_LEAD, ST_SR_LEAD: cas_n = 1'b0;
            ST_RAS_LO1, ST_RAS_LO2, ST_SR_HOLD: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            default: ;
        endcase
    end

    assert_cas_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && ras_n) |-> $past(bus_gnt));
    assert_cas_before_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
    assert_lead_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |=> !ras_n);
    assert_idle_strobes_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> (ras_n && cas_n && $past(ras_n) && $past(cas_n)));
endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;
    localparam int EXIT_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic [7:0] ivl_cmp = 8'd4;
    logic [2:0] burst_sel = 3'd0;
    logic       self_req = 1'b0;
    logic       gnt_en = 1'b0;
    logic       bus_gnt;
    logic       bus_req, ras_n, cas_n, idle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    byte exp_q[$];

    assign bus_gnt = gnt_en & bus_req;

    dram_refresh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .ivl_cmp(ivl_cmp),
        .burst_sel(burst_sel), .self_req(self_req), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .idle(idle)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chk(1'b0, "watchdog", "run did not finish", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // monitor: rebuilds each strobe event and compares it with the scoreboard
    int  ph = 0;
    int  lead_c = 0, low_c = 0, high_c = 2;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cas_n && ras_n) begin
                if (ph != 1) begin
                    chk(high_c >= 2, "R7", "precharge before CAS", high_c, 2);
                    lead_c = 0;
                end
                ph = 1;
                lead_c++;
            end else if (!cas_n && !ras_n) begin
                if (ph == 1) begin
                    ph = 2;
                    low_c = 0;
                end
                low_c++;
            end else if (cas_n && ras_n) begin
                if (ph == 2) begin
                    byte kind;
                    kind = (low_c == 2) ? "A" : "S";
                    chk(lead_c == 1, "R7", "CAS-only lead length", lead_c, 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6", "unexpected strobe event", int'(kind), 0);
                    end else begin
                        byte e;
                        e = exp_q.pop_front();
                        chk(kind == e, "R9", "event kind (A=65,S=83)", int'(kind), int'(e));
                    end
                    high_c = 0;
                end
                ph = 0;
                high_c++;
            end else begin
                chk(1'b0, "R7", "RAS low with CAS high", 0, 1);
            end
        end
    end

    task automatic push(input byte k, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(k);
    endtask

    task automatic wait_done(output int rises);
        logic prev;
        int   n;
        prev  = bus_req;
        rises = 0;
        n     = 0;
        do begin
            @(negedge clk);
            if (bus_req && !prev) rises++;
            prev = bus_req;
            n++;
        end while (!(idle && exp_q.size() == 0) && n < 30000);
        chk(exp_q.size() == 0, "R4", "expected events left over", exp_q.size(), 0);
        chk(idle && !bus_req, "R8", "bus released after burst", int'(bus_req), 0);
    endtask

    task automatic wait_rise(output int t);
        logic prev;
        prev = bus_req;
        forever begin
            @(negedge clk);
            if (bus_req && !prev) break;
            prev = bus_req;
        end
        t = cyc;
    endtask

    task automatic meas_period(input logic [2:0] sel, input logic [7:0] cmpv, input int exp_p);
        int t0, t1, t2, r;
        gnt_en    = 1'b1;
        burst_sel = 3'd0;
        push("A", 3);
        ivl_cmp   = cmpv;
        div_sel   = sel;
        wait_rise(t0);
        wait_rise(t1);
        wait_rise(t2);
        div_sel = 3'd0;
        chk(t2 - t1 == exp_p, "R3", "request period", t2 - t1, exp_p);
        wait_done(r);
    endtask

    task automatic burst_case(input logic [2:0] code, input int n);
        int t, r;
        gnt_en    = 1'b0;
        burst_sel = code;
        ivl_cmp   = 8'd4;
        div_sel   = 3'd1;
        wait_rise(t);
        div_sel = 3'd0;
        push("A", n);
        gnt_en = 1'b1;
        wait_done(r);
        chk(r == 0, "R8", "bus_req gap inside burst", r, 0);
    endtask

    initial begin
        int t, r, hi, exitc;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(ras_n && cas_n, "R1", "strobes during reset", {ras_n, cas_n}, 3);
        chk(!bus_req && idle, "R1", "bus_req/idle during reset", {bus_req, idle}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !bus_req && idle, "R1", "state after reset",
            {ras_n, cas_n, bus_req, idle}, 13);

        // R2 code 0 halts the interval counter
        gnt_en  = 1'b1;
        ivl_cmp = 8'd1;
        hi = 0;
        repeat (3000) begin
            @(negedge clk);
            if (bus_req) hi++;
        end
        chk(hi == 0, "R2", "requests with prescaler stopped", hi, 0);

        // R2/R3 divide ratios and compare values
        meas_period(3'd1, 8'd5, 20);
        meas_period(3'd2, 8'd3, 48);
        meas_period(3'd4, 8'd2, 512);
        meas_period(3'd7, 8'd2, 8192);

        // R4 credits per firing
        burst_case(3'd0, 1);
        burst_case(3'd1, 2);
        burst_case(3'd2, 4);
        burst_case(3'd3, 6);
        burst_case(3'd4, 8);
        burst_case(3'd7, 8);

        // R5/R6 grant withheld, credits pile up to the limit
        gnt_en    = 1'b0;
        burst_sel = 3'd4;
        ivl_cmp   = 8'd2;
        div_sel   = 3'd1;
        repeat (80) @(negedge clk);
        chk(bus_req, "R6", "request held without grant", int'(bus_req), 1);
        chk(ras_n && cas_n, "R6", "no strobe without grant", {ras_n, cas_n}, 3);
        div_sel = 3'd0;
        push("A", 15);
        gnt_en = 1'b1;
        wait_done(r);
        chk(r == 0, "R8", "bus_req gap in saturated burst", r, 0);

        // R9/R10 plain self-refresh entry and exit
        self_req = 1'b1;
        push("S", 1);
        while (ras_n) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(!ras_n && !cas_n, "R9", "strobes held in self-refresh", {ras_n, cas_n}, 0);
        self_req = 1'b0;
        exitc = 0;
        do begin
            @(negedge clk);
            if (!idle) begin
                exitc++;
                if (!ras_n || !cas_n)
                    chk(1'b0, "R10", "strobe low during exit", {ras_n, cas_n}, 3);
            end
        end while (!idle);
        chk(exitc == EXIT_CYC, "R10", "exit delay cycles", exitc, EXIT_CYC);
        chk(!bus_req, "R10", "bus released after exit", int'(bus_req), 0);
        chk(exp_q.size() == 0, "R9", "self event seen", exp_q.size(), 0);

        // R9 priority of self request over a pending credit
        gnt_en    = 1'b0;
        burst_sel = 3'd0;
        ivl_cmp   = 8'd3;
        div_sel   = 3'd1;
        wait_rise(t);
        div_sel  = 3'd0;
        self_req = 1'b1;
        push("S", 1);
        push("A", 1);
        @(negedge clk);
        gnt_en = 1'b1;
        repeat (12) @(negedge clk);
        self_req = 1'b0;
        wait_done(r);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule